// File: doc/BRIEF.md
# Serial Link with Clear-to-Send / Request-to-Send Handshake

This block pairs an 8N1 asynchronous transmitter and receiver that share one 16x sample enable. Each side has its own mode bit for hardware flow control. The two handshake pins are active low. When the transmit gating bit is set, the transmitter sends only while the incoming clear-to-send line is low. It checks that line only at character boundaries, so a character that has begun is always sent to its stop bit.

The receiver finds a start bit on the falling edge of the line and confirms it half a bit later. It assembles eight data bits, LSB first, and checks the stop bit. Good characters go into an 8-entry receive FIFO. When the FIFO is full, one more character waits in a holding register.

When the receive control bit is set, the receiver drives the request-to-send output high in one case only: the FIFO is full and the start of one further character has been confirmed. The peer stops after that character, so nine characters are held. The output goes low again as soon as a FIFO read frees an entry.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset, `txd` is 1, `rx_valid` is 0, `rtsn_out` is 0, and `tx_ready` is 1 while `cts_gate_en` is 0.
- R2: An accepted byte (`tx_valid` and `tx_ready` both high at a clock edge) goes out on `txd` as one 0 start bit, then eight data bits LSB first, then one 1 stop bit. Each bit lasts 16 `tick16` pulses, and the start bit appears the cycle after acceptance.
- R3: With `cts_gate_en` = 1, no frame starts and `tx_ready` stays 0 while the synchronized `ctsn_in` is 1. A frame starts once `ctsn_in` is low.
- R4: With `cts_gate_en` = 1, a rise of `ctsn_in` during a frame does not cut that frame short. It is sent complete, and no further frame starts while `ctsn_in` stays high.
- R5: With `cts_gate_en` = 0, the level of `ctsn_in` has no effect on the transmitter.
- R6: Each 8N1 frame received on `rxd` (LSB first, stop bit 1) is delivered on `rx_data` in arrival order. It is marked by `rx_valid`, and a pulse on `rx_pop` removes it.
- R7: A low pulse on `rxd` that ends before mid-bit (fewer than 8 ticks) is discarded and delivers nothing.
- R8: With `rts_ctl_en` = 1, `rtsn_out` stays 0 while the FIFO holds 8 or fewer characters with no further start bit. It goes to 1 once the FIFO is full and the start bit of a ninth character is confirmed.
- R9: The ninth character, received while the FIFO is full, is kept and delivered after the first eight, in order.
- R10: A FIFO read (`rx_pop` with `rx_valid` high) returns `rtsn_out` to 0 on the next cycle.
- R11: With `rts_ctl_en` = 0, `rtsn_oe` is 0 and `rtsn_out` stays 0, even when the FIFO overflows into the holding register.
- R12: A frame whose stop bit is 0 is discarded. The receiver waits for the line to return high and then receives the next frame correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable, 16 per bit time |
| cts_gate_en | input | 1 | Mode: clear-to-send gates the transmitter |
| rts_ctl_en | input | 1 | Mode: receiver drives request-to-send |
| ctsn_in | input | 1 | Clear-to-send, active low, asynchronous |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, asynchronous |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_pop | input | 1 | Remove oldest received byte |
| rtsn_out | output | 1 | Request-to-send level, active low |
| rtsn_oe | output | 1 | Request-to-send output enable |

## Verification
The transmitter is driven with random bytes under three clear-to-send conditions:
- Gating off while the line is high, which separates R5 from R3.
- Gating on with the line held high before the request, which shows that starts are blocked.
- The line rising partway through a frame, which separates "finish the character" from "abort".

The receiver gets random bytes with random gaps, a short false start and a frame with a bad stop bit. The flow-control case sends exactly nine characters with no reads between them. Sampling the request-to-send output after the eighth character and again early in the ninth separates the trigger "full plus a new start bit" from a plain full-level trigger. The same burst with the control bit off shows that the pin is left undriven.

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int OVS        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              cts_gate_en,
  input  logic              rts_ctl_en,
  input  logic              ctsn_in,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_pop,
  output logic              rtsn_out,
  output logic              rtsn_oe
);
  localparam int CNT_W  = $clog2(OVS);
  localparam int HALF   = OVS / 2;
  localparam int TBIT_W = $clog2(DATA_W + 2);
  localparam int RBIT_W = $clog2(DATA_W);
  localparam int PTR_W  = $clog2(FIFO_DEPTH);
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);

  // ---------------- transmitter ----------------
  logic [1:0]        cts_sync;
  logic              tx_busy;
  logic [DATA_W+1:0] tx_sh;
  logic [CNT_W-1:0]  tx_tick;
  logic [TBIT_W-1:0] tx_bit;
  logic              tx_start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cts_sync <= 2'b11;
    else        cts_sync <= {cts_sync[0], ctsn_in};

  assign tx_ready = !tx_busy && (!cts_gate_en || !cts_sync[1]);
  assign tx_start = tx_valid && tx_ready;
  assign txd      = tx_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_tick <= '0;
      tx_bit  <= '0;
    end else if (tx_start) begin
      tx_busy <= 1'b1;
      tx_sh   <= {1'b1, tx_data, 1'b0};
      tx_tick <= '0;
      tx_bit  <= '0;
    end else if (tx_busy && tick16) begin
      if (tx_tick == CNT_W'(OVS - 1)) begin
        tx_tick <= '0;
        tx_sh   <= {1'b1, tx_sh[DATA_W+1:1]};
        if (tx_bit == TBIT_W'(DATA_W + 1)) tx_busy <= 1'b0;
        else                               tx_bit  <= tx_bit + 1'b1;
      end else begin
        tx_tick <= tx_tick + 1'b1;
      end
    end
  end

  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !txd);
  p_cts_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_gate_en && cts_sync[1] && !tx_busy) |=> !tx_busy);
  p_cts_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_gate_en && !tx_busy && tx_valid) |=> tx_busy);

  // ---------------- receiver ----------------
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT} rx_st_t;
  rx_st_t            rx_st;
  logic [1:0]        rx_sync;
  logic              rx_s;
  logic [CNT_W-1:0]  rx_tick;
  logic [RBIT_W-1:0] rx_bit;
  logic [DATA_W-1:0] rx_sh;
  logic              start_ok, frame_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};
  assign rx_s = rx_sync[1];

  assign start_ok = (rx_st == RX_START) && tick16 && (rx_tick == CNT_W'(HALF - 1)) && !rx_s;
  assign frame_ok = (rx_st == RX_STOP) && tick16 && (rx_tick == CNT_W'(OVS - 1)) && rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st   <= RX_IDLE;
      rx_tick <= '0;
      rx_bit  <= '0;
      rx_sh   <= '0;
    end else begin
      case (rx_st)
        RX_IDLE:
          if (tick16 && !rx_s) begin
            rx_st   <= RX_START;
            rx_tick <= '0;
          end
        RX_START:
          if (tick16) begin
            if (rx_tick == CNT_W'(HALF - 1)) begin
              rx_tick <= '0;
              rx_bit  <= '0;
              rx_st   <= rx_s ? RX_IDLE : RX_DATA;
            end else rx_tick <= rx_tick + 1'b1;
          end
        RX_DATA:
          if (tick16) begin
            if (rx_tick == CNT_W'(OVS - 1)) begin
              rx_tick <= '0;
              rx_sh   <= {rx_s, rx_sh[DATA_W-1:1]};
              if (rx_bit == RBIT_W'(DATA_W - 1)) rx_st  <= RX_STOP;
              else                               rx_bit <= rx_bit + 1'b1;
            end else rx_tick <= rx_tick + 1'b1;
          end
        RX_STOP:
          if (tick16) begin
            if (rx_tick == CNT_W'(OVS - 1)) begin
              rx_tick <= '0;
              rx_st   <= rx_s ? RX_IDLE : RX_WAIT;
            end else rx_tick <= rx_tick + 1'b1;
          end
        default:
          if (rx_s) rx_st <= RX_IDLE;
      endcase
    end
  end

  // ---------------- FIFO, holding register, request-to-send ----------------
  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  lvl;
  logic              fifo_full, pend, push_pend, push_new, push, pop, rts_hold;
  logic [DATA_W-1:0] pend_data, push_data;

  assign fifo_full = (lvl == LVL_W'(FIFO_DEPTH));
  assign push_pend = pend && !fifo_full;
  assign push_new  = frame_ok && !pend && !fifo_full;
  assign push      = push_pend || push_new;
  assign push_data = push_pend ? pend_data : rx_sh;
  assign pop       = rx_pop && (lvl != '0);
  assign rx_valid  = (lvl != '0);
  assign rx_data   = mem[rd_ptr];

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      lvl       <= '0;
      pend      <= 1'b0;
      pend_data <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      lvl <= lvl + LVL_W'(push) - LVL_W'(pop);
      if (frame_ok && (pend ? !fifo_full : fifo_full)) begin
        pend      <= 1'b1;
        pend_data <= rx_sh;
      end else if (push_pend) begin
        pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      rts_hold <= 1'b0;
    else if (!rts_ctl_en || pop)     rts_hold <= 1'b0;
    else if (start_ok && fifo_full)  rts_hold <= 1'b1;

  assign rtsn_out = rts_hold;
  assign rtsn_oe  = rts_ctl_en;

  p_fifo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LVL_W'(FIFO_DEPTH));
  p_rts_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_hold) |-> $past(fifo_full));
  p_pend_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(fifo_full));
  p_rts_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !rtsn_out);
  p_rts_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_ctl_en |=> !rtsn_out);
endmodule

// File: tb/tb_uart_flow_ctl.sv
module tb_uart_flow_ctl;
  logic       clk = 0, rst_n = 0, tick16;
  logic       cts_gate_en = 0, rts_ctl_en = 0, ctsn_in = 1;
  logic [7:0] tx_data = 0;
  logic       tx_valid = 0, tx_ready, txd;
  logic       rxd = 1, rx_valid, rx_pop = 0, rtsn_out, rtsn_oe;
  logic [7:0] rx_data;
  int total = 0, bad = 0;

  uart_flow_ctl dut (.clk(clk), .rst_n(rst_n), .tick16(tick16), .cts_gate_en(cts_gate_en),
    .rts_ctl_en(rts_ctl_en), .ctsn_in(ctsn_in), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_pop(rx_pop), .rtsn_out(rtsn_out), .rtsn_oe(rtsn_oe));

  always #5 clk = ~clk;
  always @(posedge clk)
    if (!rst_n) tick16 <= 1'b0;
    else        tick16 <= ~tick16;

  function automatic logic [9:0] exp_frame(input logic [7:0] b);
    return {1'b1, b, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_tx(input logic [7:0] b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic tx_capture(output logic [9:0] fr);
    @(negedge clk);
    while (txd) @(negedge clk);
    repeat (16) @(negedge clk);
    fr[0] = txd;
    for (int i = 1; i < 10; i++) begin
      repeat (32) @(negedge clk);
      fr[i] = txd;
    end
  endtask

  task automatic rx_send(input logic [7:0] b, input logic stopb);
    logic [9:0] f;
    f = {stopb, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rxd = f[i];
      repeat (31) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1;
  endtask

  task automatic pop_check(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, rx_valid, 1);
    chk(req, rx_data, exp);
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] fr;
    logic [7:0] b;
    logic [7:0] q[$];
    int lows, seen;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 rtsn_out", rtsn_out, 0);
    chk("R1 tx_ready", tx_ready, 1);

    // R5 / R2: gating off, ctsn high, random bytes
    ctsn_in = 1;
    for (int k = 0; k < 3; k++) begin
      b = 8'($urandom);
      fork send_tx(b); tx_capture(fr); join
      chk("R2 R5 frame", fr, exp_frame(b));
    end
    b = 8'h00;
    fork send_tx(b); tx_capture(fr); join
    chk("R2 frame zero", fr, exp_frame(b));

    // R3: gating on, ctsn high blocks start
    repeat (40) @(negedge clk);
    cts_gate_en = 1;
    b = 8'($urandom);
    tx_data = b;
    tx_valid = 1;
    lows = 0;
    repeat (100) begin @(negedge clk); if (!txd) lows++; end
    chk("R3 no start", lows, 0);
    chk("R3 tx_ready", tx_ready, 0);
    fork
      tx_capture(fr);
      begin
        ctsn_in = 0;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 0;
      end
    join
    chk("R3 frame after release", fr, exp_frame(b));

    // R4: ctsn rises mid frame
    repeat (40) @(negedge clk);
    b = 8'hA5;
    fork
      send_tx(b);
      tx_capture(fr);
      begin repeat (100) @(negedge clk); ctsn_in = 1; end
    join
    chk("R4 frame completed", fr, exp_frame(b));
    tx_data = 8'h3C;
    tx_valid = 1;
    lows = 0;
    repeat (400) begin @(negedge clk); if (!txd) lows++; end
    chk("R4 halted", lows, 0);
    tx_valid = 0;
    cts_gate_en = 0;

    // R6 / R11: nine bytes, rts control off
    rts_ctl_en = 0;
    seen = 0;
    for (int k = 0; k < 9; k++) begin
      b = 8'($urandom);
      q.push_back(b);
      fork
        rx_send(b, 1);
        begin
          repeat (320) begin
            @(negedge clk);
            if (rtsn_out || rtsn_oe) seen++;
          end
        end
      join
      repeat ($urandom_range(0, 20)) @(negedge clk);
    end
    chk("R11 rtsn undriven", seen, 0);
    while (q.size() > 0) pop_check("R6 order", q.pop_front());
    @(negedge clk);
    chk("R6 empty", rx_valid, 0);

    // R7: false start
    @(negedge clk); rxd = 0;
    repeat (8) @(negedge clk); rxd = 1;
    repeat (400) @(negedge clk);
    chk("R7 false start", rx_valid, 0);
    b = 8'($urandom);
    rx_send(b, 1);
    pop_check("R7 next frame", b);

    // R12: bad stop bit
    rx_send(8'h5A, 0);
    repeat (64) @(negedge clk);
    chk("R12 discarded", rx_valid, 0);
    b = 8'($urandom);
    rx_send(b, 1);
    pop_check("R12 resync", b);

    // R8 / R9 / R10: rts control on
    rts_ctl_en = 1;
    repeat (40) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      b = 8'($urandom);
      q.push_back(b);
      rx_send(b, 1);
    end
    @(negedge clk);
    chk("R8 full no start", rtsn_out, 0);
    chk("R8 oe", rtsn_oe, 1);
    b = 8'($urandom);
    q.push_back(b);
    fork
      rx_send(b, 1);
      begin repeat (40) @(negedge clk); chk("R8 ninth start", rtsn_out, 1); end
    join
    repeat (10) @(negedge clk);
    chk("R8 held", rtsn_out, 1);
    pop_check("R9 first", q.pop_front());
    chk("R10 release", rtsn_out, 0);
    while (q.size() > 0) pop_check("R9 order", q.pop_front());
    @(negedge clk);
    chk("R9 empty", rx_valid, 0);
    chk("R10 stays low", rtsn_out, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule